// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a two-bank synchronous DRAM on every rising clock edge and works out which command the controller issued. It keeps, per bank, whether a row is open and which row it is. It runs a burst counter for each bank, applies per-access auto-precharge when a burst ends, and honours both single-bank and all-bank precharge. It tells auto refresh apart from self refresh by the clock-enable pin, and it raises a one-cycle protocol-error flag for illegal sequences.

On the data side it produces a write enable for the data pins that follows the mask with no delay, and a read output enable that follows the mask two clocks later. A verification environment or a memory model can sit beside a controller and use the decoded command, the bank state and the data-pin controls to follow what the memory should be doing cycle by cycle.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high the command is an inhibit: `cmd_o` reads 0 after the edge and no bank, counter or register state changes. With `cs_n` low and `ras_n`, `cas_n`, `we_n` all high the command is a no-operation, and `cmd_o` reads 1.
- R2: With `cs_n` low, the pins (`ras_n`,`cas_n`,`we_n`) decode as follows: L,H,H activate (`cmd_o`=2); H,L,H read (3); H,L,L write (4); H,H,L burst stop (5); L,H,L precharge (6); L,L,H refresh, which is auto refresh (7) with `cke` high and self-refresh entry (8) with `cke` low; L,L,L mode load (9). `cmd_o` is registered and shows the command one cycle after the edge that sampled it. A command ignored during self refresh shows as 10.
- R3: `proto_err_o` pulses for one cycle after a read or write to a bank with no open row, or after an activate to a bank that already has an open row. The offending command changes no bank state.
- R4: Activate opens the row on `addr` in the bank chosen by `ba` (0 selects bank 0, 1 selects bank 1). Bank b's row appears at `open_rows_o[b*11 +: 11]`, and bit b of `row_open_o` rises.
- R5: Precharge with `addr[10]` low closes only the bank named by `ba`. With `addr[10]` high it closes both banks, whatever `ba` holds.
- R6: A read or write lasts `burst_len` beats, counting the command cycle as the first. `burst_active_o[b]` is high for the `burst_len`-1 cycles that follow. If `addr[10]` was high on the access, the row closes at the edge of the last beat. A new access to a different bank ends any running burst without closing its row.
- R7: Burst stop ends every running burst at once, leaves every row open, and cancels any pending auto-precharge.
- R8: Self-refresh entry sets `self_ref_o`. While it is set, every command is ignored, including the one on the edge where `cke` returns high. That edge clears `self_ref_o`.
- R9: Each auto refresh increments `ref_count_o` by one. Self-refresh entry leaves it unchanged.
- R10: `dq_rd_oe_o` is high two cycles after a cycle in which a read beat was on the bus and `dqm` was low. If `dqm` was high in that cycle, the output stays low.
- R11: `dq_we_o` is high in the same cycle in which a write beat (the command cycle or a burst continuation) is on the bus with `dqm` low. It is low whenever `dqm` is high.
- R12: Mode load stores {`ba`, `addr`} in `mode_o`, with `ba` as the top bit.
- R13: Synchronous active-high `rst` closes all rows and clears the bursts, the refresh counter, the mode value, the error flag, self refresh and the read-enable pipeline. It also sets `cmd_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 1 | Bank address |
| addr | input | 11 | Row/column address; bit 10 selects precharge scope and auto-precharge |
| dqm | input | 1 | Data mask, high blocks |
| burst_len | input | 4 | Beats per access (0 behaves as 1) |
| cmd_o | output | 4 | Last decoded command code |
| row_open_o | output | 2 | Open-row flag per bank |
| open_rows_o | output | 22 | Open row address per bank |
| burst_active_o | output | 2 | Burst continuing per bank |
| proto_err_o | output | 1 | Protocol error pulse |
| self_ref_o | output | 1 | Self refresh in progress |
| ref_count_o | output | 11 | Auto-refresh row counter |
| mode_o | output | 12 | Latched mode op-code |
| dq_we_o | output | 1 | Data-pin write enable, zero delay |
| dq_rd_oe_o | output | 1 | Data-pin read output enable, two-cycle delay |

## Verification
All state outputs (`cmd_o`, the bank flags and rows, the burst flags, the error pulse, self refresh, the counter and the mode value) change at the edge that samples a command. The bench therefore checks them shortly after that edge. `dq_we_o` is combinational from the pins, so it is checked after the inputs settle and before the edge. `dq_rd_oe_o` lags the mask by two edges. The read test changes `dqm` on every beat and checks each value two edges after the cycle that set it. The auto-precharge and burst-stop tests count edges from the access command to find the edge at which the row must close or stay open.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

    typedef enum logic [3:0] {
        CMD_INH  = 4'd0,
        CMD_NOP  = 4'd1,
        CMD_ACT  = 4'd2,
        CMD_RD   = 4'd3,
        CMD_WR   = 4'd4,
        CMD_BST  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_AREF = 4'd7,
        CMD_SREF = 4'd8,
        CMD_LMR  = 4'd9,
        CMD_IDLE = 4'd10
    } cmd_e;

    // Per-bank strobes produced by the decoder for one cycle
    typedef struct packed {
        logic act;   // open a row
        logic rw;    // start an access
        logic ap;    // access carries auto-precharge
        logic wr;    // access is a write
        logic stop;  // end the running burst
        logic pre;   // close the row
    } bank_ctl_t;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n,
                                         input logic cke);
        if (cs_n) return CMD_INH;
        case ({ras_n, cas_n, we_n})
            3'b111:  return CMD_NOP;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b110:  return CMD_BST;
            3'b010:  return CMD_PRE;
            3'b001:  return cke ? CMD_AREF : CMD_SREF;
            default: return CMD_LMR;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int NUM_BANKS = 2,
    parameter int BA_W      = 1
) (
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic                  cke,
    input  logic [BA_W-1:0]       ba,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  self_ref_i,
    input  logic [NUM_BANKS-1:0]  row_open_i,
    output cmd_e                  cmd_o,
    output bank_ctl_t [NUM_BANKS-1:0] ctl_o,
    output logic                  err_o,
    output logic                  aref_o,
    output logic                  sref_o,
    output logic                  lmr_o
);
    localparam int AP_BIT = ADDR_W - 1;

    cmd_e raw;
    logic is_rw;
    logic tgt_open;

    always_comb begin
        raw      = decode_pins(cs_n, ras_n, cas_n, we_n, cke);
        cmd_o    = self_ref_i ? CMD_IDLE : raw;
        is_rw    = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);
        tgt_open = row_open_i[ba];
        err_o    = ((cmd_o == CMD_ACT) && tgt_open) || (is_rw && !tgt_open);
        aref_o   = (cmd_o == CMD_AREF);
        sref_o   = (cmd_o == CMD_SREF);
        lmr_o    = (cmd_o == CMD_LMR);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(b));
        always_comb begin
            ctl_o[b].act  = (cmd_o == CMD_ACT) && sel && !row_open_i[b];
            ctl_o[b].rw   = is_rw && sel && row_open_i[b];
            ctl_o[b].ap   = addr[AP_BIT];
            ctl_o[b].wr   = (cmd_o == CMD_WR);
            ctl_o[b].stop = (cmd_o == CMD_BST) || (is_rw && !sel && tgt_open);
            ctl_o[b].pre  = (cmd_o == CMD_PRE) && (addr[AP_BIT] || sel);
        end
    end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BL_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_ctl_t         ctl_i,
    input  logic [ADDR_W-1:0] row_i,
    input  logic [BL_W-1:0]   bl_i,
    output logic              open_o,
    output logic [ADDR_W-1:0] row_o,
    output logic              busy_o,
    output logic              busy_wr_o
);
    logic [BL_W-1:0] rem;
    logic            ap_q;
    logic            wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_o <= 1'b0;
            row_o  <= '0;
            busy_o <= 1'b0;
            rem    <= '0;
            ap_q   <= 1'b0;
            wr_q   <= 1'b0;
        end else if (ctl_i.pre) begin
            open_o <= 1'b0;
            busy_o <= 1'b0;
            ap_q   <= 1'b0;
        end else if (ctl_i.act) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (ctl_i.rw) begin
            wr_q <= ctl_i.wr;
            if (bl_i <= BL_W'(1)) begin
                busy_o <= 1'b0;
                ap_q   <= 1'b0;
                if (ctl_i.ap) open_o <= 1'b0;
            end else begin
                busy_o <= 1'b1;
                rem    <= bl_i - BL_W'(1);
                ap_q   <= ctl_i.ap;
            end
        end else if (ctl_i.stop) begin
            busy_o <= 1'b0;
            ap_q   <= 1'b0;
        end else if (busy_o) begin
            rem <= rem - BL_W'(1);
            if (rem == BL_W'(1)) begin
                busy_o <= 1'b0;
                ap_q   <= 1'b0;
                if (ap_q) open_o <= 1'b0;
            end
        end
    end

    assign busy_wr_o = busy_o && wr_q;

endmodule

// File: rtl/sdram_dq_ctrl.sv
module sdram_dq_ctrl #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dqm_i,
    input  logic rd_win_i,
    input  logic wr_win_i,
    output logic dq_we_o,
    output logic dq_rd_oe_o
);
    logic [RD_LAT-1:0] pipe;
    logic              rd_now;

    assign rd_now  = rd_win_i && !dqm_i;
    assign dq_we_o = wr_win_i && !dqm_i;

    if (RD_LAT == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= rd_now;
        end
    end else begin : g_multi
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[RD_LAT-2:0], rd_now};
        end
    end

    assign dq_rd_oe_o = pipe[RD_LAT-1];

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int NUM_BANKS = 2,
    parameter int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int BL_W      = 4,
    parameter int RD_LAT    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        cke,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        dqm,
    input  logic [BL_W-1:0]             burst_len,
    output logic [3:0]                  cmd_o,
    output logic [NUM_BANKS-1:0]        row_open_o,
    output logic [NUM_BANKS*ADDR_W-1:0] open_rows_o,
    output logic [NUM_BANKS-1:0]        burst_active_o,
    output logic                        proto_err_o,
    output logic                        self_ref_o,
    output logic [ADDR_W-1:0]           ref_count_o,
    output logic [ADDR_W+BA_W-1:0]      mode_o,
    output logic                        dq_we_o,
    output logic                        dq_rd_oe_o
);
    cmd_e                      dec_cmd;
    bank_ctl_t [NUM_BANKS-1:0] ctl;
    logic                      dec_err, dec_aref, dec_sref, dec_lmr;
    logic [NUM_BANKS-1:0]      busy_wr;
    logic                      rd_win, wr_win;

    sdram_cmd_decode #(
        .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BA_W(BA_W)
    ) u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .ba(ba), .addr(addr), .self_ref_i(self_ref_o), .row_open_i(row_open_o),
        .cmd_o(dec_cmd), .ctl_o(ctl), .err_o(dec_err), .aref_o(dec_aref),
        .sref_o(dec_sref), .lmr_o(dec_lmr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_state #(.ADDR_W(ADDR_W), .BL_W(BL_W)) u_bank (
            .clk(clk), .rst(rst), .ctl_i(ctl[b]), .row_i(addr), .bl_i(burst_len),
            .open_o(row_open_o[b]), .row_o(open_rows_o[b*ADDR_W +: ADDR_W]),
            .busy_o(burst_active_o[b]), .busy_wr_o(busy_wr[b])
        );
    end

    always_comb begin
        rd_win = 1'b0;
        wr_win = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ctl[b].rw &&  ctl[b].wr) wr_win = 1'b1;
            if (ctl[b].rw && !ctl[b].wr) rd_win = 1'b1;
            if (busy_wr[b])              wr_win = 1'b1;
            if (burst_active_o[b] && !busy_wr[b]) rd_win = 1'b1;
        end
    end

    sdram_dq_ctrl #(.RD_LAT(RD_LAT)) u_dq (
        .clk(clk), .rst(rst), .dqm_i(dqm), .rd_win_i(rd_win), .wr_win_i(wr_win),
        .dq_we_o(dq_we_o), .dq_rd_oe_o(dq_rd_oe_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o       <= CMD_NOP;
            proto_err_o <= 1'b0;
            self_ref_o  <= 1'b0;
            ref_count_o <= '0;
            mode_o      <= '0;
        end else begin
            cmd_o       <= dec_cmd;
            proto_err_o <= dec_err;
            if (self_ref_o && cke) self_ref_o <= 1'b0;
            else if (dec_sref)     self_ref_o <= 1'b1;
            if (dec_aref) ref_count_o <= ref_count_o + 1'b1;
            if (dec_lmr)  mode_o <= {ba, addr};
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
    parameter int ADDR_W    = 11,
    parameter int NUM_BANKS = 2,
    parameter int BA_W      = 1,
    parameter int RD_LAT    = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic                   cke,
    input logic [BA_W-1:0]        ba,
    input logic [ADDR_W-1:0]      addr,
    input logic                   dqm,
    input logic [NUM_BANKS-1:0]   row_open_o,
    input logic [NUM_BANKS-1:0]   burst_active_o,
    input logic                   proto_err_o,
    input logic                   self_ref_o,
    input logic [ADDR_W-1:0]      ref_count_o,
    input logic                   dq_rd_oe_o
);
    a_r3_access_closed: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ras_n && !cas_n && !self_ref_o && !row_open_o[ba]) |=> proto_err_o);

    a_r3_act_open: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && we_n && !self_ref_o && row_open_o[ba]) |=> proto_err_o);

    a_r4_act_opens: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && we_n && !self_ref_o) |=> row_open_o[$past(ba)]);

    a_r5_pre_all: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && cas_n && !we_n && addr[ADDR_W-1] && !self_ref_o)
        |=> (row_open_o == '0));

    a_r6_one_burst: assert property (@(posedge clk) disable iff (rst)
        $onehot0(burst_active_o));

    a_r8_sref_frozen: assert property (@(posedge clk) disable iff (rst)
        self_ref_o |=> ($stable(row_open_o) && $stable(ref_count_o)));

    a_r9_aref_step: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && !cas_n && we_n && cke && !self_ref_o)
        |=> (ref_count_o == ADDR_W'($past(ref_count_o) + 1'b1)));

    if (RD_LAT == 2) begin : g_lat2
        a_r10_rd_mask: assert property (@(posedge clk) disable iff (rst)
            dq_rd_oe_o |-> !$past(dqm, 2));
    end

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .RD_LAT(RD_LAT)
) u_chk (.*);

// File: tb/sdram_cmd_tracker_bench.sv
module sdram_cmd_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [0:0]  ba = '0;
    logic [10:0] addr = '0;
    logic        dqm = 1'b1;
    logic [3:0]  burst_len = 4'd1;
    logic [3:0]  cmd_o;
    logic [1:0]  row_open_o, burst_active_o;
    logic [21:0] open_rows_o;
    logic        proto_err_o, self_ref_o, dq_we_o, dq_rd_oe_o;
    logic [10:0] ref_count_o;
    logic [11:0] mode_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_tracker u_sdram_cmd_tracker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
        .burst_len(burst_len), .cmd_o(cmd_o), .row_open_o(row_open_o),
        .open_rows_o(open_rows_o), .burst_active_o(burst_active_o),
        .proto_err_o(proto_err_o), .self_ref_o(self_ref_o),
        .ref_count_o(ref_count_o), .mode_o(mode_o), .dq_we_o(dq_we_o),
        .dq_rd_oe_o(dq_rd_oe_o)
    );

    typedef struct packed {
        logic        cs, ras, cas, we, b;
        logic [10:0] a;
        logic [3:0]  cmd;
        logic [1:0]  open;
        logic        err;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,11'h000,4'd0,2'b00,1'b0}, // inhibit
        '{1'b0,1'b1,1'b1,1'b1,1'b0,11'h000,4'd1,2'b00,1'b0}, // nop
        '{1'b0,1'b0,1'b1,1'b1,1'b0,11'h123,4'd2,2'b01,1'b0}, // act b0
        '{1'b0,1'b0,1'b1,1'b1,1'b0,11'h456,4'd2,2'b01,1'b1}, // act b0 again
        '{1'b0,1'b1,1'b0,1'b1,1'b1,11'h000,4'd3,2'b01,1'b1}, // read closed b1
        '{1'b0,1'b0,1'b1,1'b1,1'b1,11'h7FF,4'd2,2'b11,1'b0}, // act b1
        '{1'b0,1'b1,1'b0,1'b0,1'b1,11'h010,4'd4,2'b11,1'b0}, // write b1
        '{1'b0,1'b1,1'b0,1'b1,1'b0,11'h400,4'd3,2'b10,1'b0}, // read b0 autopre
        '{1'b0,1'b1,1'b0,1'b0,1'b0,11'h000,4'd4,2'b10,1'b1}, // write closed b0
        '{1'b0,1'b0,1'b1,1'b0,1'b1,11'h000,4'd6,2'b00,1'b0}, // pre b1
        '{1'b0,1'b0,1'b1,1'b1,1'b0,11'h055,4'd2,2'b01,1'b0}, // act b0
        '{1'b0,1'b0,1'b1,1'b1,1'b1,11'h2AA,4'd2,2'b11,1'b0}, // act b1
        '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h400,4'd6,2'b00,1'b0}, // pre all
        '{1'b0,1'b0,1'b1,1'b1,1'b1,11'h2AA,4'd2,2'b10,1'b0}, // act b1
        '{1'b0,1'b0,1'b1,1'b0,1'b0,11'h000,4'd6,2'b10,1'b0}, // pre b0 only
        '{1'b1,1'b0,1'b1,1'b1,1'b0,11'h111,4'd0,2'b10,1'b0}, // inhibit over act
        '{1'b0,1'b1,1'b1,1'b0,1'b0,11'h000,4'd5,2'b10,1'b0}  // burst stop idle
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                         input logic k, input logic b, input logic [10:0] a, input logic m);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a; dqm = m;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic nop(input logic m);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 11'h000, m);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R13 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R13 reset state
        chk("R13 row_open", row_open_o, 0);
        chk("R13 cmd", cmd_o, 1);
        chk("R13 ref_count", ref_count_o, 0);
        chk("R13 rd_oe", dq_rd_oe_o, 0);

        // R1 R2 R3 R4 R5: vector walk, burst length 1
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].cs, VEC[i].ras, VEC[i].cas, VEC[i].we, 1'b1, VEC[i].b, VEC[i].a, 1'b1);
            tick();
            chk($sformatf("R2 cmd vec%0d", i), cmd_o, VEC[i].cmd);
            chk($sformatf("R5 open vec%0d", i), row_open_o, VEC[i].open);
            chk($sformatf("R3 err vec%0d", i), proto_err_o, VEC[i].err);
        end
        chk("R4 bank1 row", open_rows_o[21:11], 11'h2AA);
        chk("R1 ref_count untouched", ref_count_o, 0);

        // R6 R11 write burst with auto-precharge
        burst_len = 4'd4;
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'h123, 1'b1);
        tick();
        chk("R4 bank0 row", open_rows_o[10:0], 11'h123);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 11'h400, 1'b0);
        chk("R11 we on command", dq_we_o, 1);
        tick();
        chk("R6 busy after cmd", burst_active_o, 2'b01);
        nop(1'b1);
        chk("R11 we masked", dq_we_o, 0);
        tick();
        chk("R6 busy beat2", burst_active_o, 2'b01);
        nop(1'b0);
        chk("R11 we continuing", dq_we_o, 1);
        tick();
        chk("R6 open before end", row_open_o, 2'b11);
        nop(1'b1);
        tick();
        chk("R6 busy ended", burst_active_o, 2'b00);
        chk("R6 autopre closed", row_open_o, 2'b10);

        // R7 burst stop cancels auto-precharge
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h400, 1'b1);
        tick();
        chk("R7 busy", burst_active_o, 2'b10);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'h000, 1'b1);
        tick();
        chk("R7 stopped", burst_active_o, 2'b00);
        for (int i = 0; i < 3; i++) begin nop(1'b1); tick(); end
        chk("R7 row kept", row_open_o, 2'b10);

        // R10 read output enable two cycles after mask
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 11'h000, 1'b0);
        tick();
        chk("R10 e0", dq_rd_oe_o, 0);
        nop(1'b1); tick();
        chk("R10 e1", dq_rd_oe_o, 1);
        nop(1'b0); tick();
        chk("R10 e2", dq_rd_oe_o, 0);
        nop(1'b0); tick();
        chk("R10 e3", dq_rd_oe_o, 1);
        nop(1'b0); tick();
        chk("R10 e4", dq_rd_oe_o, 1);
        nop(1'b0); tick();
        chk("R10 e5", dq_rd_oe_o, 0);

        // R9 auto refresh
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 11'h000, 1'b1);
            tick();
        end
        chk("R9 count", ref_count_o, 3);
        chk("R2 aref code", cmd_o, 7);

        // R8 self refresh
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'h000, 1'b1);
        tick();
        chk("R8 entered", self_ref_o, 1);
        chk("R2 sref code", cmd_o, 8);
        chk("R9 no count on sref", ref_count_o, 3);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'h0AB, 1'b1);
        tick();
        chk("R8 ignored", row_open_o, 2'b10);
        chk("R8 idle code", cmd_o, 10);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'h0AB, 1'b1);
        tick();
        chk("R8 exited", self_ref_o, 0);
        chk("R8 exit cmd ignored", row_open_o, 2'b10);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'h0AB, 1'b1);
        tick();
        chk("R8 decode resumed", row_open_o, 2'b11);

        // R12 mode load
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'h321, 1'b1);
        tick();
        chk("R12 mode", mode_o, 12'hB21);
        chk("R2 lmr code", cmd_o, 9);

        // R13 reset mid-run
        @(negedge clk); rst = 1'b1;
        tick();
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R13 rows closed", row_open_o, 0);
        chk("R13 count cleared", ref_count_o, 0);
        chk("R13 mode cleared", mode_o, 0);
        chk("R13 self_ref", self_ref_o, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule